// File: doc/BRIEF.md
# ATA PIO Sector Sequencer

This block is the host side of a polled CompactFlash link running in ATA task-file mode. A request gives a starting logical block address, a sector count, a direction and an optional feature byte. The sequencer first trims the request to the card's capacity. It then splits the request into commands of at most 256 sectors. For each command it programs the task-file registers and issues a read (0x20) or a write (0x30). After that it moves every sector word by word between the card's data register and a local buffer port.

The card sits on a simple request/acknowledge register bus. A request holds the register index, direction and write data until the acknowledge arrives, and read data is valid in the acknowledge cycle. The per-request width flag selects one of two data paths. In wide (16-bit) mode, full words move. In narrow (8-bit) mode, only the low byte carries data. The status byte is read from the low byte in both modes.

Status is polled before every command and before every sector, and each poll has a programmable cycle limit. The block reports completion with a one-cycle pulse. The pulse carries the number of sectors moved and two mutually exclusive flags: device error and timeout.

Top module: `ata_pio_seq`

## Requirements
- R1: The request length is min(count, capacity − lba). When lba ≥ capacity or the count is zero, done pulses with zero sectors, no flags set, and no bus access.
- R2: No task-file write happens until a status read shows bit 7 (busy) clear. The same rule applies to the busy wait before each sector. If that read also has bit 0 (error) set, the request ends with the error flag and the sectors completed so far.
- R3: Register indices are: data 0, feature 1, count 2, LBA low 3, LBA mid 4, LBA high 5, device/head 6, command/status 7. Task-file writes go in ascending index order, from feature to command. The feature write is skipped when the feature byte is zero. The command byte is 0x20 for reads and 0x30 for writes.
- R4: The device/head byte is 0xE0 | LBA[27:24]. The count register holds the command's sector count modulo 256, so 256 is written as 0.
- R5: A request is issued as consecutive commands of min(remaining, 256) sectors. Each command's LBA is the previous command's LBA plus the previous command's sector count.
- R6: Before each sector's data accesses, a status read shows busy clear, and a later status read shows bit 3 (data request) set.
- R7: A sector takes SECT_BYTES/2 data accesses in wide mode and SECT_BYTES accesses in narrow mode. In narrow mode only bits 7:0 carry data, and the upper bits are zero.
- R8: During writes, a status read is inserted after the data access with in-sector index i whenever i ≠ 0 and i mod 16 = 0. During reads, no status read occurs inside a sector.
- R9: Data word k of the request, counted from zero, is written to buffer address k on reads and fetched from buffer address k on writes.
- R10: If a busy or data-request poll stays unsatisfied past poll_limit cycles, the request ends with the timeout flag and the count of fully moved sectors.
- R11: busy rises on acceptance and stays high through the one-cycle done pulse. req_valid has no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a request (taken only while idle) |
| req_write | input | 1 | 1 = write to card, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| req_lba | input | 28 | Starting logical block address |
| req_count | input | COUNT_W | Requested sector count |
| req_feature | input | 8 | Feature byte, written only when nonzero |
| capacity | input | 28 | Card capacity in sectors |
| poll_limit | input | TO_W | Cycle limit of each status poll |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_sectors | output | COUNT_W | Sectors moved |
| done_error | output | 1 | Card reported error |
| done_timeout | output | 1 | A poll timed out |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_reg | output | 3 | Register index |
| bus_wdata | output | 16 | Register write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 16 | Register read data, valid with ack |
| buf_addr | output | COUNT_W+log2(SECT_BYTES) | Buffer word address |
| buf_wdata | output | 16 | Buffer write data (reads) |
| buf_we | output | 1 | Buffer write strobe |
| buf_rdata | input | 16 | Buffer data at buf_addr (writes) |

## Verification
A behavioural card model answers the bus. It injects a random number of busy and not-ready status replies before each sector, and it checks the order, values and LBA of every task-file write as well as each data word. Both directions are run in both width modes, and random lengths and offsets are mixed with directed cases. A 300-sector request and an exactly-256-sector request test the chunk split and the count-register wrap, and an LBA with nonzero upper bits tests the device/head byte. Requests that fall past the capacity, or have zero length, show clipping apart from normal completion. Injected error replies, before the command and in mid-request, and busy or data-request replies that never clear, check the completed-sector count that each failure path reports.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

    localparam int LBA_W     = 28;
    localparam int CHUNK_MAX = 256;

    localparam int BSY_BIT = 7;
    localparam int DRQ_BIT = 3;
    localparam int ERR_BIT = 0;

    localparam logic [7:0] CMD_READ  = 8'h20;
    localparam logic [7:0] CMD_WRITE = 8'h30;

    typedef enum logic [2:0] {
        REG_DATA  = 3'd0,
        REG_FEAT  = 3'd1,
        REG_COUNT = 3'd2,
        REG_LBA0  = 3'd3,
        REG_LBA1  = 3'd4,
        REG_LBA2  = 3'd5,
        REG_DEVHD = 3'd6,
        REG_CMDST = 3'd7
    } tf_reg_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_TASKFILE,
        ST_WAIT_BSY,
        ST_WAIT_DRQ,
        ST_XFER,
        ST_FLUSH,
        ST_SECT_END,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       write;
        logic       wide;
        logic [7:0] feat;
    } req_cfg_t;

    function automatic logic [7:0] devhead_byte(input logic [3:0] lba_top);
        return 8'hE0 | {4'h0, lba_top};
    endfunction

    // Posted-write relief: a status read follows every 16th data access,
    // never the very first one of a sector.
    function automatic logic flush_after(input logic [15:0] idx);
        return (idx != 16'd0) && (idx[3:0] == 4'd0);
    endfunction

endpackage

// File: rtl/ata_req_clip.sv
module ata_req_clip
    import ata_seq_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic [LBA_W-1:0]   lba,
    input  logic [COUNT_W-1:0] count,
    input  logic [LBA_W-1:0]   capacity,
    output logic [COUNT_W-1:0] len
);
    localparam int CW = (LBA_W > COUNT_W) ? LBA_W : COUNT_W;

    logic [CW-1:0] avail_w;
    logic [CW-1:0] count_w;

    always_comb begin
        avail_w = CW'(capacity - lba);
        count_w = CW'(count);
        if (lba >= capacity)
            len = '0;
        else if (avail_w < count_w)
            len = avail_w[COUNT_W-1:0];
        else
            len = count;
    end
endmodule

// File: rtl/ata_chunk_calc.sv
module ata_chunk_calc
    import ata_seq_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic [COUNT_W-1:0] remain,
    output logic [8:0]         chunk,
    output logic [7:0]         count_byte
);
    always_comb begin
        if (remain > COUNT_W'(CHUNK_MAX))
            chunk = 9'(CHUNK_MAX);
        else
            chunk = remain[8:0];
        count_byte = chunk[7:0];
    end
endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run && (cnt_q != '1))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_seq_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int COUNT_W    = 16,
    parameter int TO_W       = 16
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      req_valid,
    input  logic                                      req_write,
    input  logic                                      req_wide,
    input  logic [27:0]                               req_lba,
    input  logic [COUNT_W-1:0]                        req_count,
    input  logic [7:0]                                req_feature,
    input  logic [27:0]                               capacity,
    input  logic [TO_W-1:0]                           poll_limit,
    output logic                                      busy,
    output logic                                      done,
    output logic [COUNT_W-1:0]                        done_sectors,
    output logic                                      done_error,
    output logic                                      done_timeout,
    output logic                                      bus_req,
    output logic                                      bus_we,
    output logic [2:0]                                bus_reg,
    output logic [15:0]                               bus_wdata,
    input  logic                                      bus_ack,
    input  logic [15:0]                               bus_rdata,
    output logic [COUNT_W+$clog2(SECT_BYTES)-1:0]     buf_addr,
    output logic [15:0]                               buf_wdata,
    output logic                                      buf_we,
    input  logic [15:0]                               buf_rdata
);
    localparam int BUF_AW = COUNT_W + $clog2(SECT_BYTES);
    localparam int IDX_W  = $clog2(SECT_BYTES + 1);
    localparam logic [IDX_W-1:0] WORDS_WIDE   = IDX_W'(SECT_BYTES / 2);
    localparam logic [IDX_W-1:0] WORDS_NARROW = IDX_W'(SECT_BYTES);

    seq_state_e           state_q;
    req_cfg_t             cfg_q;
    tf_reg_e              tf_q;
    logic [LBA_W-1:0]     lba_q;
    logic [COUNT_W-1:0]   remain_q;
    logic [COUNT_W-1:0]   sect_cnt_q;
    logic [8:0]           sec_left_q;
    logic [IDX_W-1:0]     widx_q;
    logic [BUF_AW-1:0]    baddr_q;
    logic                 err_q;
    logic                 to_q;

    logic [COUNT_W-1:0]   clip_len;
    logic [8:0]           chunk_w;
    logic [7:0]           count_byte;
    logic                 polling;
    logic                 timer_clear;
    logic                 expired;
    logic [7:0]           st;
    logic [IDX_W-1:0]     sect_words;
    logic [7:0]           tf_byte;

    ata_req_clip #(.COUNT_W(COUNT_W)) clip_i (
        .lba      (req_lba),
        .count    (req_count),
        .capacity (capacity),
        .len      (clip_len)
    );

    ata_chunk_calc #(.COUNT_W(COUNT_W)) chunk_i (
        .remain     (remain_q),
        .chunk      (chunk_w),
        .count_byte (count_byte)
    );

    assign polling     = (state_q == ST_WAIT_RDY) || (state_q == ST_WAIT_BSY) ||
                         (state_q == ST_WAIT_DRQ);
    assign st          = bus_rdata[7:0];
    assign timer_clear = !polling ||
                         ((state_q == ST_WAIT_BSY) && bus_ack && !st[BSY_BIT]);

    ata_poll_timer #(.TO_W(TO_W)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (timer_clear),
        .run     (polling),
        .limit   (poll_limit),
        .expired (expired)
    );

    assign sect_words = cfg_q.wide ? WORDS_WIDE : WORDS_NARROW;

    always_comb begin
        unique case (tf_q)
            REG_FEAT:  tf_byte = cfg_q.feat;
            REG_COUNT: tf_byte = count_byte;
            REG_LBA0:  tf_byte = lba_q[7:0];
            REG_LBA1:  tf_byte = lba_q[15:8];
            REG_LBA2:  tf_byte = lba_q[23:16];
            REG_DEVHD: tf_byte = devhead_byte(lba_q[27:24]);
            REG_CMDST: tf_byte = cfg_q.write ? CMD_WRITE : CMD_READ;
            default:   tf_byte = 8'h00;
        endcase
    end

    always_comb begin
        bus_req   = polling || (state_q == ST_TASKFILE) || (state_q == ST_XFER) ||
                    (state_q == ST_FLUSH);
        bus_we    = (state_q == ST_TASKFILE) || ((state_q == ST_XFER) && cfg_q.write);
        bus_reg   = (state_q == ST_TASKFILE) ? tf_q :
                    (state_q == ST_XFER)     ? REG_DATA : REG_CMDST;
        if (state_q == ST_TASKFILE)
            bus_wdata = {8'h00, tf_byte};
        else
            bus_wdata = cfg_q.wide ? buf_rdata : {8'h00, buf_rdata[7:0]};
        buf_wdata = cfg_q.wide ? bus_rdata : {8'h00, bus_rdata[7:0]};
        buf_we    = (state_q == ST_XFER) && !cfg_q.write && bus_ack;
    end

    assign buf_addr     = baddr_q;
    assign busy         = (state_q != ST_IDLE);
    assign done         = (state_q == ST_DONE);
    assign done_sectors = sect_cnt_q;
    assign done_error   = err_q;
    assign done_timeout = to_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            tf_q       <= REG_FEAT;
            lba_q      <= '0;
            remain_q   <= '0;
            sect_cnt_q <= '0;
            sec_left_q <= '0;
            widx_q     <= '0;
            baddr_q    <= '0;
            err_q      <= 1'b0;
            to_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    cfg_q      <= '{write: req_write, wide: req_wide, feat: req_feature};
                    lba_q      <= req_lba;
                    remain_q   <= clip_len;
                    sect_cnt_q <= '0;
                    baddr_q    <= '0;
                    err_q      <= 1'b0;
                    to_q       <= 1'b0;
                    state_q    <= (clip_len == '0) ? ST_DONE : ST_WAIT_RDY;
                end
                ST_WAIT_RDY: if (bus_ack) begin
                    if (!st[BSY_BIT]) begin
                        if (st[ERR_BIT]) begin
                            err_q   <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            tf_q    <= (cfg_q.feat != 8'h00) ? REG_FEAT : REG_COUNT;
                            state_q <= ST_TASKFILE;
                        end
                    end else if (expired) begin
                        to_q    <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_TASKFILE: if (bus_ack) begin
                    if (tf_q == REG_CMDST) begin
                        sec_left_q <= chunk_w;
                        state_q    <= ST_WAIT_BSY;
                    end else begin
                        tf_q <= tf_reg_e'(3'(tf_q) + 3'd1);
                    end
                end
                ST_WAIT_BSY: if (bus_ack) begin
                    if (!st[BSY_BIT]) begin
                        if (st[ERR_BIT]) begin
                            err_q   <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_WAIT_DRQ;
                        end
                    end else if (expired) begin
                        to_q    <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_WAIT_DRQ: if (bus_ack) begin
                    if (st[DRQ_BIT]) begin
                        widx_q  <= '0;
                        state_q <= ST_XFER;
                    end else if (expired) begin
                        to_q    <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_XFER: if (bus_ack) begin
                    widx_q  <= widx_q + 1'b1;
                    baddr_q <= baddr_q + 1'b1;
                    if (cfg_q.write && flush_after(16'(widx_q)))
                        state_q <= ST_FLUSH;
                    else if (widx_q == sect_words - 1'b1)
                        state_q <= ST_SECT_END;
                end
                ST_FLUSH: if (bus_ack) begin
                    state_q <= (widx_q == sect_words) ? ST_SECT_END : ST_XFER;
                end
                ST_SECT_END: begin
                    sect_cnt_q <= sect_cnt_q + 1'b1;
                    sec_left_q <= sec_left_q - 1'b1;
                    if (sec_left_q == 9'd1) begin
                        lba_q    <= lba_q + LBA_W'(chunk_w);
                        remain_q <= remain_q - COUNT_W'(chunk_w);
                        state_q  <= (remain_q == COUNT_W'(chunk_w)) ? ST_DONE : ST_WAIT_RDY;
                    end else begin
                        state_q <= ST_WAIT_BSY;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        done_error,
    input logic        done_timeout,
    input logic        bus_req,
    input logic        bus_we,
    input logic [2:0]  bus_reg,
    input logic [15:0] bus_wdata,
    input logic        bus_ack,
    input logic        buf_we
);
    p_bus_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_reg) && $stable(bus_we)));

    p_cmd_code_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_reg == 3'd7) |-> (bus_wdata == 16'h0020 || bus_wdata == 16'h0030));

    p_devhead_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_reg == 3'd6) |-> (bus_wdata[15:4] == 12'h00E));

    p_bufwe_read_r9: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (bus_ack && !bus_we && bus_reg == 3'd0));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !(done_error && done_timeout));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_busy_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);
endmodule

bind ata_pio_seq ata_pio_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .done_error   (done_error),
    .done_timeout (done_timeout),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_reg      (bus_reg),
    .bus_wdata    (bus_wdata),
    .bus_ack      (bus_ack),
    .buf_we       (buf_we)
);

// File: tb/ata_pio_seq_tb_top.sv
module ata_pio_seq_tb_top;
    localparam int SB = 64;
    localparam int CW = 16;
    localparam int TW = 16;
    localparam int AW = CW + $clog2(SB);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [27:0]   req_lba = '0, capacity = 28'd1000;
    logic [CW-1:0] req_count = '0;
    logic [7:0]    req_feature = '0;
    logic [TW-1:0] poll_limit = TW'(40);
    logic          busy, done, done_error, done_timeout;
    logic [CW-1:0] done_sectors;
    logic          bus_req, bus_we, bus_ack;
    logic [2:0]    bus_reg;
    logic [15:0]   bus_wdata, bus_rdata;
    logic [AW-1:0] buf_addr;
    logic [15:0]   buf_wdata, buf_rdata;
    logic          buf_we;

    ata_pio_seq #(.SECT_BYTES(SB), .COUNT_W(CW), .TO_W(TW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_lba(req_lba), .req_count(req_count),
        .req_feature(req_feature), .capacity(capacity), .poll_limit(poll_limit),
        .busy(busy), .done(done), .done_sectors(done_sectors), .done_error(done_error),
        .done_timeout(done_timeout), .bus_req(bus_req), .bus_we(bus_we),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_we(buf_we), .buf_rdata(buf_rdata)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rpat(input int a, input int base);
        return 16'(a * 37 + base * 11 + 9);
    endfunction

    function automatic logic [15:0] wpat(input int a);
        return 16'(a * 29 + 3) ^ 16'hA5C3;
    endfunction

    // card model configuration and state
    bit          m_wide, m_write;
    logic [7:0]  m_feat;
    int          m_base;
    bit          inj_err, inj_stuck;
    int          inj_err_sec = -1, inj_nodrq_sec = -1;
    int          ph, busy_left, drq_wait, sec_left, widx, gsec, gword, tf_exp, c_remain;
    longint      exp_lba;
    bit          saw_rdy;
    int          v_order, v_val, v_proto, v_data, v_buf, n_dummy, n_cmds, n_bufwr, n_data;
    logic [7:0]  tfr [0:7];
    logic [15:0] rd_tmp;

    function automatic logic [15:0] mask();
        return m_wide ? 16'hFFFF : 16'h00FF;
    endfunction

    function automatic int words();
        return m_wide ? SB / 2 : SB;
    endfunction

    task automatic new_sector();
        ph = 1;
        busy_left = $urandom % 3;
        drq_wait  = $urandom % 2;
    endtask

    task automatic advance();
        n_data++;
        widx++;
        gword++;
        if (widx == words()) begin
            widx = 0;
            gsec++;
            sec_left--;
            if (sec_left == 0) ph = 0;
            else new_sector();
        end
    endtask

    task automatic card_wr(input logic [2:0] r, input logic [15:0] d);
        int chunk;
        if (r == 3'd0) begin
            if (ph != 2) v_proto++;
            if (d !== (wpat(gword) & mask())) v_data++;
            advance();
        end else begin
            if (ph != 0) v_proto++;
            if (int'(r) != tf_exp) v_order++;
            tf_exp = int'(r) + 1;
            tfr[r] = d[7:0];
            if (r == 3'd1 && d[7:0] != m_feat) v_val++;
            if (r == 3'd7) begin
                chunk = (c_remain > 256) ? 256 : c_remain;
                if (!saw_rdy) v_proto++;
                if (d[7:0] != (m_write ? 8'h30 : 8'h20)) v_val++;
                if (tfr[2] != 8'(chunk)) v_val++;
                if ({tfr[6][3:0], tfr[5], tfr[4], tfr[3]} != 28'(exp_lba)) v_val++;
                if (tfr[6][7:4] != 4'hE) v_val++;
                exp_lba  += chunk;
                c_remain -= chunk;
                sec_left = (tfr[2] == 8'd0) ? 256 : int'(tfr[2]);
                n_cmds++;
                saw_rdy = 0;
                tf_exp  = (m_feat != 8'd0) ? 1 : 2;
                new_sector();
            end
        end
    endtask

    task automatic card_rd(input logic [2:0] r, output logic [15:0] d);
        d = 16'h0000;
        if (r == 3'd0) begin
            if (ph != 2) v_proto++;
            d = rpat(gword, m_base) & mask();
            advance();
        end else if (r == 3'd7) begin
            if (inj_stuck) d = 16'h0080;
            else if (ph == 0) begin
                d = inj_err ? 16'h0051 : 16'h0050;
                saw_rdy = 1;
            end else if (ph == 1) begin
                if (busy_left > 0) begin
                    busy_left--;
                    d = 16'h0080;
                end else if (gsec == inj_err_sec) begin
                    d = 16'h0051;
                end else if (gsec == inj_nodrq_sec || drq_wait > 0) begin
                    if (drq_wait > 0) drq_wait--;
                    d = 16'h0050;
                end else begin
                    ph = 2;
                    d = 16'h0058;
                end
            end else begin
                if (widx > 0) n_dummy++;
                d = 16'h0058;
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= 16'h0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) card_wr(bus_reg, bus_wdata);
            else begin
                card_rd(bus_reg, rd_tmp);
                bus_rdata <= rd_tmp;
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    assign buf_rdata = wpat(int'(buf_addr));

    always @(posedge clk) begin
        if (!rst && buf_we) begin
            n_bufwr++;
            if (buf_wdata !== (rpat(int'(buf_addr), m_base) & mask())) v_buf++;
        end
    end

    int  cyc_all = 0;
    bit  wd_fired = 0;
    always @(negedge clk) begin
        cyc_all++;
        if (cyc_all > 190000 && !wd_fired) begin
            wd_fired = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 190000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run(input longint lba, input int cnt, input longint cap, input bit wr,
                       input bit wide, input logic [7:0] feat, input int exp_sec_in,
                       input bit exp_err, input bit exp_to, input bit full, input string tag);
        int clip, nw, cyc, exp_sec;
        clip = (lba >= cap) ? 0 : (((cap - lba) < cnt) ? int'(cap - lba) : cnt);
        nw = wide ? SB / 2 : SB;
        exp_sec = (exp_sec_in < 0) ? clip : exp_sec_in;
        @(negedge clk);
        m_wide = wide; m_write = wr; m_feat = feat; m_base = int'(lba);
        exp_lba = lba; c_remain = clip;
        ph = 0; gsec = 0; gword = 0; widx = 0; saw_rdy = 0;
        tf_exp = (feat != 8'd0) ? 1 : 2;
        v_order = 0; v_val = 0; v_proto = 0; v_data = 0; v_buf = 0;
        n_dummy = 0; n_cmds = 0; n_bufwr = 0; n_data = 0;
        req_lba = 28'(lba); req_count = CW'(cnt); capacity = 28'(cap);
        req_write = wr; req_wide = wide; req_feature = feat; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, {"R11 busy after accept ", tag}, busy, 1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 120000) begin
            // R11: a request while busy must be ignored
            if (cyc == 6 && busy) begin
                req_lba   = req_lba ^ 28'h1;
                req_valid = 1'b1;
            end else req_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        req_lba   = 28'(lba);
        check(done === 1'b1, {"R11 done reached ", tag}, done, 1);
        check(int'(done_sectors) == exp_sec, {"R1 R10 sectors ", tag}, done_sectors, exp_sec);
        check(done_error == exp_err, {"R2 error flag ", tag}, done_error, exp_err);
        check(done_timeout == exp_to, {"R10 timeout flag ", tag}, done_timeout, exp_to);
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, {"R11 single done pulse ", tag}, {busy, done}, 0);
        if (full) begin
            check(n_cmds == (clip + 255) / 256, {"R5 command count ", tag}, n_cmds, (clip + 255) / 256);
            check(v_order == 0, {"R3 task-file order ", tag}, v_order, 0);
            check(v_val == 0, {"R4 R5 task-file values ", tag}, v_val, 0);
            check(v_proto == 0, {"R2 R6 status gating ", tag}, v_proto, 0);
            check(n_data == clip * nw, {"R7 data accesses ", tag}, n_data, clip * nw);
            check(n_dummy == (wr ? clip * ((nw - 1) / 16) : 0), {"R8 inserted status reads ", tag},
                  n_dummy, wr ? clip * ((nw - 1) / 16) : 0);
            if (wr) check(v_data == 0, {"R9 write data ", tag}, v_data, 0);
            else begin
                check(v_buf == 0, {"R9 read data ", tag}, v_buf, 0);
                check(n_bufwr == clip * nw, {"R9 buffer writes ", tag}, n_bufwr, clip * nw);
            end
        end
        inj_err = 0; inj_stuck = 0; inj_err_sec = -1; inj_nodrq_sec = -1;
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        inj_err = 0; inj_stuck = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && bus_req === 1'b0, "R11 reset state",
              {busy, done, bus_req}, 0);

        // R1: clipping and empty requests
        run(1000, 5, 1000, 0, 1, 8'h00, -1, 0, 0, 1, "past capacity");
        run(10, 0, 1000, 1, 1, 8'h00, -1, 0, 0, 1, "zero count");
        run(995, 10, 1000, 0, 1, 8'h00, -1, 0, 0, 1, "clipped tail");

        // both widths, both directions, feature skip and write
        run(7, 3, 1000, 0, 1, 8'h00, -1, 0, 0, 1, "wide read");
        run(40, 4, 1000, 1, 1, 8'h03, -1, 0, 0, 1, "wide write feat");
        run(123, 3, 1000, 0, 0, 8'h00, -1, 0, 0, 1, "narrow read");
        run(321, 3, 1000, 1, 0, 8'h41, -1, 0, 0, 1, "narrow write");

        // R4: upper LBA nibble in device/head
        run(28'h5A0_0010, 2, 28'hFFF_FFFF, 0, 0, 8'h00, -1, 0, 0, 1, "high lba");

        // R5: chunk split and count wrap
        run(100, 300, 1000, 0, 1, 8'h00, -1, 0, 0, 1, "300 sector split");
        run(0, 256, 1000, 1, 1, 8'h00, -1, 0, 0, 1, "256 sector wrap");

        for (int i = 0; i < 8; i++) begin
            int  l, c;
            bit  w, wd;
            logic [7:0] f;
            l  = $urandom % 1100;
            c  = $urandom % 20;
            w  = 1'($urandom % 2);
            wd = 1'($urandom % 2);
            f  = ($urandom % 2) ? 8'(($urandom % 255) + 1) : 8'h00;
            run(l, c, 1000, w, wd, f, -1, 0, 0, 1, "random");
        end

        // R2: error before command and error in mid-request
        inj_err = 1;
        run(50, 4, 1000, 0, 1, 8'h00, 0, 1, 0, 0, "error before command");
        inj_err_sec = 2;
        run(60, 5, 1000, 1, 0, 8'h00, 2, 1, 0, 0, "error mid-request");

        // R10: busy never clears, data request never rises
        inj_stuck = 1;
        run(70, 4, 1000, 0, 1, 8'h00, 0, 0, 1, 0, "stuck busy");
        inj_nodrq_sec = 3;
        run(80, 6, 1000, 0, 1, 8'h00, 3, 0, 1, 0, "missing data request");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule